// File: doc/BRIEF.md
# One-Wire ID Memory MAC Address Fetcher

This block is a sequencer that sits in front of a byte-level one-wire bus master and turns the contents of a small identification memory into a 48-bit Ethernet MAC address. A single-cycle `start` pulse launches one transaction. The block first asks the master for a bus reset and checks for a presence reply. It then writes a fixed four-byte command script: skip the device address, read memory, and a start address of zero. After that it reads one byte that it drops, and then a 28-byte data block.

As each data byte arrives, the block compares a 16-byte signature window of the block against a parameter. It also keeps three address bytes. When the transaction ends it publishes a MAC address and an error code, with a one-cycle `mac_valid` pulse. The address has a fixed three-byte prefix followed by data bytes 7, 6 and 5, in that order. If the signature does not match, or no device answers, the block publishes a fallback address instead, and the error code says which of the two failures occurred.

The master is reached through two streams. The command stream (`cmd_*`) is valid/ready. Once `cmd_valid` is high, it stays high and `cmd_op`/`cmd_data` stay unchanged until the master raises `cmd_ready`, so the master may apply back-pressure for any number of cycles. The response stream (`rsp_*`) is valid/ready as well. The block raises `rsp_ready` only while it waits for the reply to the command it has just issued. Every command, including writes, gets exactly one response, and only one command is outstanding at a time. The `start` input, the result outputs and `busy` are plain signals.

Top module: `idmem_mac_fetch`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `rsp_ready` and `mac_valid` are 0, and `mac` and `err_code` are 0.
- R2: A `start` pulse while idle makes the next command a bus reset (`cmd_op` = 0). A `start` pulse while `busy` is high is ignored and does not change the command sequence or the result.
- R3: If the reset response has `rsp_presence` = 0, no further command is issued. The result is `mac` = 48'h000102030405 with `err_code` = 1.
- R4: If presence is seen, the next four commands are writes (`cmd_op` = 1) with the data bytes 0xCC, 0xF0, 0x00, 0x00, in that order.
- R5: After the writes, exactly 29 reads (`cmd_op` = 2) are issued, for 34 commands in total. The first read response is discarded and its value has no effect. The following 28 responses are data bytes 0 to 27.
- R6: Data bytes 11 to 26 must equal the 16-byte parameter `SIGNATURE`. Byte 11 is compared with the most significant character, and each later byte with the next character down. Bytes 10 and 27 are not compared. Any mismatch gives `err_code` = 2 and `mac` = 48'h00E0EEFFFFFF.
- R7: On success `err_code` = 0 and `mac` = {24'h00E0EE, byte7, byte6, byte5}, with byte 7 in bits 23:16 and byte 5 in bits 7:0.
- R8: `mac_valid` is high for exactly one cycle per transaction, in the same cycle that the new `mac`/`err_code` first appear. Both values then hold until the next accepted `start`, which clears them to 0 in the following cycle.
- R9: `cmd_valid`, `cmd_op` and `cmd_data` hold steady while `cmd_ready` is low. After a command is accepted, `cmd_valid` stays low and `rsp_ready` is high until that command's response is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one fetch transaction (honoured only when idle) |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready from the bus master |
| cmd_op | output | 2 | Command kind: 0 bus reset, 1 write byte, 2 read byte |
| cmd_data | output | 8 | Byte to write (write commands) |
| rsp_valid | input | 1 | Response stream valid from the bus master |
| rsp_ready | output | 1 | Block is waiting for a response |
| rsp_data | input | 8 | Byte read from the bus (read commands) |
| rsp_presence | input | 1 | Presence seen (reset commands) |
| mac | output | 48 | Assembled MAC address |
| mac_valid | output | 1 | One-cycle pulse when a new result is published |
| err_code | output | 2 | 0 none, 1 no device, 2 signature mismatch |
| busy | output | 1 | A transaction is in progress |

## Verification
Two functions can fall in the same cycle. The first is a second `start` arriving while the block is busy. The second is the acceptance of a command by the master. The bench raises `start` in exactly the cycle in which `cmd_ready` completes the fourth command's handshake, and it also stalls `cmd_ready` for a cycle to check that the command is held steady. The run is judged correct when the command log still has exactly 34 entries in the required order and the published address equals the one expected from the data image, unaffected by the extra pulse.

// File: rtl/idmem_pkg.sv
package idmem_pkg;

  // command kinds presented to the byte-level bus master
  localparam logic [1:0] OP_BUS_RESET = 2'd0;
  localparam logic [1:0] OP_WRITE     = 2'd1;
  localparam logic [1:0] OP_READ      = 2'd2;

  // result codes
  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_NODEV  = 2'd1;
  localparam logic [1:0] ERR_BADSIG = 2'd2;

  // fixed command script written after a successful presence check
  localparam int SCRIPT_LEN = 4;
  localparam logic [7:0] SCR_SKIP_ADDR = 8'hCC;
  localparam logic [7:0] SCR_READ_MEM  = 8'hF0;
  localparam logic [7:0] SCR_ADDR_LO   = 8'h00;
  localparam logic [7:0] SCR_ADDR_HI   = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_REQ,
    ST_RST_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_FINISH
  } seq_state_t;

endpackage

// File: rtl/idmem_script.sv
module idmem_script
  import idmem_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    script_byte
);

  always_comb begin
    case (idx)
      IW'(0):  script_byte = SCR_SKIP_ADDR;
      IW'(1):  script_byte = SCR_READ_MEM;
      IW'(2):  script_byte = SCR_ADDR_LO;
      default: script_byte = SCR_ADDR_HI;
    endcase
  end

endmodule

// File: rtl/idmem_sigchk.sv
module idmem_sigchk #(
  parameter int          CW        = 5,
  parameter int          SIG_FIRST = 11,
  parameter int          SIG_LEN   = 16,
  parameter logic [8*SIG_LEN-1:0] SIGNATURE = '0,
  parameter int          ID_LO     = 5,
  parameter int          ID_BYTES  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  byte_valid,
  input  logic [CW-1:0]         byte_idx,
  input  logic [7:0]            byte_data,
  output logic                  mismatch,
  output logic [8*ID_BYTES-1:0] id_bytes
);

  localparam int SIG_LAST = SIG_FIRST + SIG_LEN - 1;

  int unsigned idx_u;
  int unsigned rel;
  logic        in_window;
  logic [7:0]  expect_byte;

  always_comb begin
    idx_u       = 32'(byte_idx);
    in_window   = (idx_u >= SIG_FIRST) && (idx_u <= SIG_LAST);
    rel         = in_window ? (idx_u - SIG_FIRST) : 0;
    expect_byte = SIGNATURE[8*(SIG_LEN-1-rel) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mismatch <= 1'b0;
    end else if (byte_valid && in_window && (byte_data != expect_byte)) begin
      mismatch <= 1'b1;
    end
  end

  // capture slots: slot g holds data byte ID_LO+g; highest index lands in MSBs
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_cap
    logic [7:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        slot <= 8'h00;
      end else if (byte_valid && (idx_u == 32'(ID_LO + g))) begin
        slot <= byte_data;
      end
    end
    assign id_bytes[8*g +: 8] = slot;
  end

endmodule

// File: rtl/idmem_macgen.sv
module idmem_macgen
  import idmem_pkg::*;
#(
  parameter int           ID_BYTES   = 3,
  parameter logic [23:0]  MAC_PREFIX = 24'h00E0EE,
  parameter logic [47:0]  NODEV_MAC  = 48'h000102030405
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  publish,
  input  logic                  nodev,
  input  logic                  mismatch,
  input  logic [8*ID_BYTES-1:0] id_bytes,
  output logic [47:0]           mac,
  output logic [1:0]            err_code,
  output logic                  mac_valid
);

  localparam int TAIL_W = 48 - 24;

  logic [47:0] next_mac;
  logic [1:0]  next_err;

  always_comb begin
    if (nodev) begin
      next_mac = NODEV_MAC;
      next_err = ERR_NODEV;
    end else if (mismatch) begin
      next_mac = {MAC_PREFIX, {TAIL_W{1'b1}}};
      next_err = ERR_BADSIG;
    end else begin
      next_mac = {MAC_PREFIX, TAIL_W'(id_bytes)};
      next_err = ERR_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mac       <= '0;
      err_code  <= ERR_NONE;
      mac_valid <= 1'b0;
    end else if (publish) begin
      mac       <= next_mac;
      err_code  <= next_err;
      mac_valid <= 1'b1;
    end else begin
      mac_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/idmem_mac_fetch.sv
module idmem_mac_fetch
  import idmem_pkg::*;
#(
  parameter int                NUM_BYTES  = 28,
  parameter int                SIG_FIRST  = 11,
  parameter int                SIG_LEN    = 16,
  parameter logic [8*SIG_LEN-1:0] SIGNATURE = "NODE-ID-BLOCK-V1",
  parameter int                ID_LO      = 5,
  parameter logic [23:0]       MAC_PREFIX = 24'h00E0EE,
  parameter logic [47:0]       NODEV_MAC  = 48'h000102030405
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_data,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_presence,
  output logic [47:0] mac,
  output logic        mac_valid,
  output logic [1:0]  err_code,
  output logic        busy
);

  localparam int ID_BYTES = 3;
  localparam int CW       = $clog2(NUM_BYTES + 1);
  localparam int WW       = $clog2(SCRIPT_LEN);

  seq_state_t    state;
  logic [WW-1:0] wr_idx;
  logic [CW-1:0] rd_idx;
  logic          nodev;
  logic          launch;
  logic          rsp_take;
  logic          cmd_take;
  logic [7:0]    script_byte;
  logic          data_valid;
  logic [CW-1:0] data_idx;
  logic          mismatch;
  logic [8*ID_BYTES-1:0] id_bytes;
  logic          publish;

  assign launch   = (state == ST_IDLE) && start;
  assign cmd_take = cmd_valid && cmd_ready;
  assign rsp_take = rsp_valid && rsp_ready;
  assign publish  = (state == ST_FINISH);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_BUS_RESET;
    cmd_data  = 8'h00;
    rsp_ready = 1'b0;
    case (state)
      ST_RST_REQ: cmd_valid = 1'b1;
      ST_WR_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_data  = script_byte;
      end
      ST_RD_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_READ;
      end
      ST_RST_WAIT, ST_WR_WAIT, ST_RD_WAIT: rsp_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wr_idx <= '0;
      rd_idx <= '0;
      nodev  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RST_REQ;
          nodev <= 1'b0;
        end
        ST_RST_REQ: if (cmd_take) state <= ST_RST_WAIT;
        ST_RST_WAIT: if (rsp_take) begin
          if (rsp_presence) begin
            state  <= ST_WR_REQ;
            wr_idx <= '0;
          end else begin
            nodev <= 1'b1;
            state <= ST_FINISH;
          end
        end
        ST_WR_REQ: if (cmd_take) state <= ST_WR_WAIT;
        ST_WR_WAIT: if (rsp_take) begin
          if (wr_idx == WW'(SCRIPT_LEN - 1)) begin
            state  <= ST_RD_REQ;
            rd_idx <= '0;
          end else begin
            wr_idx <= wr_idx + 1'b1;
            state  <= ST_WR_REQ;
          end
        end
        ST_RD_REQ: if (cmd_take) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_take) begin
          if (rd_idx == CW'(NUM_BYTES)) begin
            state <= ST_FINISH;
          end else begin
            rd_idx <= rd_idx + 1'b1;
            state  <= ST_RD_REQ;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // read slot 0 is the command/address check byte and is dropped
  assign data_valid = (state == ST_RD_WAIT) && rsp_take && (rd_idx != '0);
  assign data_idx   = rd_idx - 1'b1;

  idmem_script #(.IW(WW)) u_script (
    .idx         (wr_idx),
    .script_byte (script_byte)
  );

  idmem_sigchk #(
    .CW        (CW),
    .SIG_FIRST (SIG_FIRST),
    .SIG_LEN   (SIG_LEN),
    .SIGNATURE (SIGNATURE),
    .ID_LO     (ID_LO),
    .ID_BYTES  (ID_BYTES)
  ) u_sig (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (launch),
    .byte_valid (data_valid),
    .byte_idx   (data_idx),
    .byte_data  (rsp_data),
    .mismatch   (mismatch),
    .id_bytes   (id_bytes)
  );

  idmem_macgen #(
    .ID_BYTES   (ID_BYTES),
    .MAC_PREFIX (MAC_PREFIX),
    .NODEV_MAC  (NODEV_MAC)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .publish   (publish),
    .nodev     (nodev),
    .mismatch  (mismatch),
    .id_bytes  (id_bytes),
    .mac       (mac),
    .err_code  (err_code),
    .mac_valid (mac_valid)
  );

endmodule

// File: rtl/idmem_mac_fetch_chk.sv
module idmem_mac_fetch_chk #(
  parameter logic [23:0] MAC_PREFIX = 24'h00E0EE,
  parameter logic [47:0] NODEV_MAC  = 48'h000102030405
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic [7:0]  cmd_data,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic        rsp_presence,
  input logic [47:0] mac,
  input logic        mac_valid,
  input logic [1:0]  err_code,
  input logic        busy
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data))); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_valid && rsp_ready)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !rsp_ready)); // R1

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mac == 48'h0 && err_code == 2'd0 && cmd_valid && cmd_op == 2'd0)); // R2

  AST_NODEV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && err_code == 2'd1) |-> (mac == NODEV_MAC)); // R3

  AST_BADSIG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && err_code == 2'd2) |-> (mac == {MAC_PREFIX, 24'hFFFFFF})); // R6

  AST_GOOD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && err_code == 2'd0) |-> (mac[47:24] == MAC_PREFIX)); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |=> (!mac_valid && $stable(mac) && $stable(err_code))); // R8

  AST_ERR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd3); // R6

endmodule

bind idmem_mac_fetch idmem_mac_fetch_chk #(
  .MAC_PREFIX (MAC_PREFIX),
  .NODEV_MAC  (NODEV_MAC)
) u_chk (.*);

// File: tb/sim_idmem_mac_fetch.sv
`timescale 1ns/1ps
module sim_idmem_mac_fetch;

  localparam logic [127:0] SIG = "NODE-ID-BLOCK-V1";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [7:0]  rsp_data = 8'h00;
  logic        rsp_presence = 1'b0;
  logic [47:0] mac;
  logic        mac_valid;
  logic [1:0]  err_code;
  logic        busy;

  int total = 0;
  int bad   = 0;

  logic [7:0]  img [28];
  logic [1:0]  log_op [64];
  logic [7:0]  log_d  [64];
  int          ncmd;
  logic [47:0] res_mac;
  logic [1:0]  res_err;

  always #4 clk = ~clk;

  idmem_mac_fetch u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_img(input logic [7:0] seed);
    for (int i = 0; i < 28; i++) img[i] = seed + 8'(i * 7);
    for (int k = 0; k < 16; k++) img[11 + k] = SIG[8*(15-k) +: 8];
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && cmd_valid && cmd_op == 2'd0, "R2 reset command first", {cmd_valid, cmd_op}, 3'b100);
    chk(mac == 48'h0 && err_code == 2'd0, "R8 start clears result", mac, 0);
  endtask

  // acts as the bus master until a result is published
  task automatic serve(input bit present, input logic [7:0] crc, input bit stall, input bit poke);
    int  guard = 0;
    int  rd_n = 0;
    bit  got = 0;
    logic [1:0] op0;
    logic [7:0] d0;
    ncmd = 0;
    while (!got && guard < 4000 && ncmd < 60) begin
      @(negedge clk); guard++;
      if (mac_valid) begin
        got = 1; res_mac = mac; res_err = err_code;
      end else if (cmd_valid) begin
        if (stall) begin
          op0 = cmd_op; d0 = cmd_data;
          @(negedge clk);
          chk(cmd_valid && cmd_op == op0 && cmd_data == d0, "R9 command held under stall",
              {cmd_valid, cmd_op, cmd_data}, {1'b1, op0, d0});
        end
        log_op[ncmd] = cmd_op; log_d[ncmd] = cmd_data;
        cmd_ready = 1'b1;
        if (poke && ncmd == 3) start = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0; start = 1'b0;
        if (ncmd < 3) chk(!cmd_valid && rsp_ready, "R9 waits for response", {cmd_valid, rsp_ready}, 2'b01);
        rsp_presence = present;
        if (log_op[ncmd] == 2'd2) begin
          rd_n++;
          rsp_data = (rd_n == 1) ? crc : img[rd_n-2];
        end else begin
          rsp_data = 8'h5A;
        end
        rsp_valid = 1'b1;
        ncmd++;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_presence = 1'b0;
      end
    end
    chk(got, "R8 result published", got, 1);
    @(negedge clk);
    chk(!mac_valid && mac == res_mac && err_code == res_err, "R8 one-cycle pulse, result held",
        {mac_valid, mac}, {1'b0, res_mac});
  endtask

  task automatic check_script();
    bit ok_w = 1, ok_r = 1;
    chk(ncmd == 34, "R5 command count", ncmd, 34);
    chk(log_op[0] == 2'd0, "R2 first command is bus reset", log_op[0], 0);
    ok_w = (log_op[1] == 2'd1 && log_d[1] == 8'hCC) && (log_op[2] == 2'd1 && log_d[2] == 8'hF0) &&
           (log_op[3] == 2'd1 && log_d[3] == 8'h00) && (log_op[4] == 2'd1 && log_d[4] == 8'h00);
    chk(ok_w, "R4 write script", {log_d[1], log_d[2], log_d[3], log_d[4]}, 32'hCCF00000);
    for (int i = 5; i < 34; i++) if (log_op[i] != 2'd2) ok_r = 0;
    chk(ok_r, "R5 read commands", ok_r, 1);
  endtask

  task automatic t_reset_state();
    chk(!busy && !cmd_valid && !rsp_ready && !mac_valid, "R1 idle controls",
        {busy, cmd_valid, rsp_ready, mac_valid}, 0);
    chk(mac == 48'h0 && err_code == 2'd0, "R1 result cleared", mac, 0);
  endtask

  task automatic t_good(input logic [7:0] seed, input logic [7:0] crc, input bit stall, input bit poke);
    logic [47:0] exp;
    fill_img(seed);
    exp = {24'h00E0EE, img[7], img[6], img[5]};
    do_start();
    serve(1'b1, crc, stall, poke);
    check_script();
    chk(res_err == 2'd0 && res_mac == exp, poke ? "R2 busy start ignored" : "R7 good address",
        res_mac, exp);
  endtask

  task automatic t_nodev();
    do_start();
    serve(1'b0, 8'h00, 1'b0, 1'b0);
    chk(ncmd == 1, "R3 no commands after absent device", ncmd, 1);
    chk(res_err == 2'd1 && res_mac == 48'h000102030405, "R3 absent device result",
        {res_err, res_mac}, {2'd1, 48'h000102030405});
  endtask

  task automatic t_badsig(input int pos);
    fill_img(8'h40);
    img[pos] = img[pos] ^ 8'h20;
    do_start();
    serve(1'b1, 8'h11, 1'b0, 1'b0);
    chk(res_err == 2'd2 && res_mac == 48'h00E0EEFFFFFF, "R6 signature mismatch",
        {res_err, res_mac}, {2'd2, 48'h00E0EEFFFFFF});
  endtask

  task automatic t_edges_outside();
    logic [47:0] exp;
    fill_img(8'h90);
    img[10] = 8'h00; img[27] = 8'hEE;
    exp = {24'h00E0EE, img[7], img[6], img[5]};
    do_start();
    serve(1'b1, 8'h77, 1'b0, 1'b0);
    chk(res_err == 2'd0 && res_mac == exp, "R6 bytes 10 and 27 not compared", res_mac, exp);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    chk(!busy && !mac_valid && mac == res_mac, "R8 result holds while idle", mac, res_mac);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_good(8'h11, 8'hA5, 1'b0, 1'b0);
    t_hold();
    t_good(8'h03, 8'hFF, 1'b1, 1'b0);
    t_nodev();
    t_badsig(11);
    t_badsig(26);
    t_edges_outside();
    t_good(8'hC8, 8'h00, 1'b1, 1'b1);
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule